// File: doc/BRIEF.md
# Serial Receiver with Per-Character Line Status

This block turns a single asynchronous serial line into characters. Each frame is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit and a stop bit. Bit timing comes from an external enable that pulses sixteen times per bit period. Received characters go into a sixteen-entry queue, or into a single holding slot when queue mode is off. A processor reads them through a data strobe and checks a line status word through a status strobe.

Each stored character carries its own parity, framing and break flags. The status word shows the flags of the oldest unread character only. A sticky overrun flag reports characters that were lost. Reading the status word clears the error bits. When enabled, any error bit drives a line-status interrupt. A framing error does not make the receiver wait for a new edge: the low stop sample is taken as the next start bit. A break is held in the queue as exactly one zero character.

Top module: `uart_rx_lsr`

## Requirements
- R1: Status bit 0 (data ready) is 1 in the cycle after a character is stored. It stays 1 until every stored character has been read through the data strobe, then it returns to 0.
- R2: A start bit counts only if the line is still low at the eighth enable after the falling edge was seen. A low pulse shorter than that stores nothing.
- R3: Field word_len selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Data bits are received least significant bit first. Unused upper bits of rd_data read as 0.
- R4: When par_en is 1, one parity bit follows the data. par_even=1 selects even parity and par_even=0 selects odd parity. A mismatch sets the character's parity flag, which shows in status bit 2.
- R5: A stop bit sampled low sets the character's framing flag, which shows in status bit 3. The receiver then treats that low sample as a confirmed start bit and reads the next data bits from it at once.
- R6: If the line stays low from the start bit through the stop sample (a break), exactly one character 0x00 is stored with break (bit 4) and framing (bit 3) set and parity (bit 2) clear. Nothing more is stored until the line goes high and a new valid start bit arrives.
- R7: Parity, framing and break flags belong to their own character. They appear in status bits 2 to 4 only while that character is the oldest unread one. Status bits 7 to 5 always read 0.
- R8: A status strobe clears status bits 1 to 4, meaning the overrun flag and the flags of the current oldest character. An overrun in the same cycle as the strobe still leaves bit 1 set.
- R9: With fifo_mode=0, a character that arrives while the holding slot is still unread replaces the held one and sets overrun (status bit 1).
- R10: With fifo_mode=1 and 16 characters stored, a further completed character is discarded and overrun is set at once. The 16 stored characters stay intact.
- R11: lsi_irq is 1 exactly when lsi_en is 1 and at least one of status bits 1 to 4 is 1.
- R12: After reset, line_stat, rd_data and lsi_irq are 0.
- R13: The receiver advances only on cycles where sample_en is 1. One bit lasts 16 such enables, whatever the enable rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Oversampling enable, 16 per bit period |
| rx_in | input | 1 | Serial line, idle high |
| fifo_mode | input | 1 | 1 selects the 16-entry queue, 0 selects a single holding slot |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| word_len | input | 2 | Data bits minus five |
| lsi_en | input | 1 | Line-status interrupt enable |
| rd_data_stb | input | 1 | Remove the oldest character |
| rd_stat_stb | input | 1 | Status read, clears error bits |
| rd_data | output | 8 | Oldest character, 0 when none |
| line_stat | output | 8 | Bit 0 ready, 1 overrun, 2 parity, 3 framing, 4 break |
| lsi_irq | output | 1 | Line-status interrupt |

## Verification
A wrong bit counter or sample phase shows up as corrupted data or a false framing flag on the very next character read. A flag stored against the wrong queue slot shows up when that slot reaches the head: the error appears one character early or late. A miscounted fill level shows up either as an overrun that arrives too soon, on the sixteenth character instead of the seventeenth, or as data ready dropping while characters remain. Each of these can be seen at the ports within one frame of the faulty event.

// File: rtl/uart_rx_pkg.sv
// Shared types of the serial receiver: one stored character with its flags.
package uart_rx_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              pe;
        logic              fe;
        logic              bi;
    } rx_entry_t;
endpackage

// File: rtl/uart_rx_deser.sv
// Frame deserializer. Oversamples the line on tick, confirms the start bit
// at mid-bit, then shifts in data, parity and stop. Emits one entry per frame.
// Assumes tick pulses OVS times per bit and the configuration is steady
// during a frame.
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic       par_en,
    input  logic       par_even,
    input  logic [1:0] word_len,
    output logic       out_valid,
    output rx_entry_t  out_entry
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

    st_t               st;
    logic [CW-1:0]     cnt;
    logic [2:0]        idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              seen_one;
    logic [2:0]        last_idx;
    logic [DATA_W-1:0] aligned;
    logic              par_bad;
    logic              is_break;

    // Last data index, right-aligned data word and error checks for the stop sample.
    always_comb begin
        last_idx = {1'b0, word_len} + 3'd4;
        aligned  = shreg >> (2'd3 - word_len);
        par_bad  = par_en & ((^aligned ^ par_bit) == par_even);
        is_break = ~rx & ~seen_one;
    end

    // Receive state machine, advanced on oversampling ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            seen_one  <= 1'b0;
            out_valid <= 1'b0;
            out_entry <= '0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                case (st)
                    S_IDLE: begin
                        if (!rx) begin
                            st  <= S_START;
                            cnt <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == MID) begin
                            cnt      <= '0;
                            idx      <= '0;
                            seen_one <= 1'b0;
                            st       <= rx ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == LAST) begin
                            cnt      <= '0;
                            shreg    <= {rx, shreg[DATA_W-1:1]};
                            seen_one <= seen_one | rx;
                            if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
                            else                 idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == LAST) begin
                            cnt      <= '0;
                            par_bit  <= rx;
                            seen_one <= seen_one | rx;
                            st       <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == LAST) begin
                            cnt            <= '0;
                            out_valid      <= 1'b1;
                            out_entry.data <= is_break ? '0 : aligned;
                            out_entry.pe   <= par_bad & ~is_break;
                            out_entry.fe   <= ~rx;
                            out_entry.bi   <= is_break;
                            if (is_break) begin
                                st <= S_BRK;
                            end else if (!rx) begin
                                st       <= S_DATA;
                                idx      <= '0;
                                seen_one <= 1'b0;
                            end else begin
                                st <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_BRK: begin
                        if (rx) st <= S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
// Character queue with per-entry flags. In queue mode it holds DEPTH entries
// and drops arrivals when full. In single-slot mode it holds one entry and
// overwrites it. Assumes the mode changes only while empty.
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_mode,
    input  logic                       push,
    input  rx_entry_t                  push_entry,
    input  logic                       pop,
    input  logic                       clr_flags,
    output rx_entry_t                  head,
    output logic                       empty,
    output logic                       ovr_evt,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

    rx_entry_t          mem [DEPTH];
    logic [PW-1:0]      rd_ptr;
    logic [PW-1:0]      wr_ptr;
    logic [CNW-1:0]     limit;
    logic               full;
    logic               do_pop;
    logic               do_write;

    // Occupancy limits and the accept or overrun decision for this cycle.
    always_comb begin
        limit    = fifo_mode ? CNW'(DEPTH) : CNW'(1);
        empty    = (count == '0);
        full     = (count >= limit);
        do_pop   = pop & ~empty;
        ovr_evt  = push & full & ~do_pop;
        do_write = push & ~(full & ~do_pop);
        head     = mem[rd_ptr];
    end

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop)   rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            if (do_write) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            if (do_write && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_write) count <= count - 1'b1;
        end
    end

    // Entry storage: flag clearing at the head, then writes (a new entry wins).
    always_ff @(posedge clk) begin
        if (clr_flags && !empty && !do_pop) begin
            mem[rd_ptr].pe <= 1'b0;
            mem[rd_ptr].fe <= 1'b0;
            mem[rd_ptr].bi <= 1'b0;
        end
        if (do_write) mem[wr_ptr] <= push_entry;
        else if (ovr_evt && !fifo_mode) mem[rd_ptr] <= push_entry;
    end
endmodule

// File: rtl/uart_rx_lsr.sv
// Receiver top: deserializer, character queue, overrun flag and the status
// word built from the head entry. Assumes rd strobes last one cycle each.
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       rx_in,
    input  logic       fifo_mode,
    input  logic       par_en,
    input  logic       par_even,
    input  logic [1:0] word_len,
    input  logic       lsi_en,
    input  logic       rd_data_stb,
    input  logic       rd_stat_stb,
    output logic [7:0] rd_data,
    output logic [7:0] line_stat,
    output logic       lsi_irq
);
    localparam int CNW = $clog2(DEPTH + 1);

    logic           rx_valid;
    rx_entry_t      rx_entry;
    rx_entry_t      head;
    logic           fifo_empty;
    logic           ovr_evt;
    logic [CNW-1:0] fifo_count;
    logic           oe_q;

    uart_rx_deser #(.OVS(OVS)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_en),
        .rx        (rx_in),
        .par_en    (par_en),
        .par_even  (par_even),
        .word_len  (word_len),
        .out_valid (rx_valid),
        .out_entry (rx_entry)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .push       (rx_valid),
        .push_entry (rx_entry),
        .pop        (rd_data_stb),
        .clr_flags  (rd_stat_stb),
        .head       (head),
        .empty      (fifo_empty),
        .ovr_evt    (ovr_evt),
        .count      (fifo_count)
    );

    // Sticky overrun flag: a new overrun beats the clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)           oe_q <= 1'b0;
        else if (ovr_evt)     oe_q <= 1'b1;
        else if (rd_stat_stb) oe_q <= 1'b0;
    end

    // Status word and data from the head entry, masked while empty.
    always_comb begin
        rd_data   = fifo_empty ? '0 : head.data;
        line_stat = {3'b000,
                     head.bi & ~fifo_empty,
                     head.fe & ~fifo_empty,
                     head.pe & ~fifo_empty,
                     oe_q,
                     ~fifo_empty};
        lsi_irq   = lsi_en & (|line_stat[4:1]);
    end
endmodule

// File: rtl/uart_rx_lsr_chk.sv
// Property checker for the receiver top, attached with bind below.
module uart_rx_lsr_chk #(
    parameter int DEPTH = 16,
    parameter int CNW   = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rx_valid,
    input logic           rd_stat_stb,
    input logic           fifo_mode,
    input logic [CNW-1:0] fifo_count,
    input logic [7:0]     line_stat,
    input logic [7:0]     rd_data
);
    // R1: a stored character makes data ready visible next cycle
    a_r1_ready_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> line_stat[0]);

    // R8: a status read with no arrival leaves overrun clear
    a_r8_oe_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_stb && !rx_valid) |=> !line_stat[1]);

    // R6: a break entry at the head reads as zero with framing set
    a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
        line_stat[4] |-> (rd_data == 8'h00 && line_stat[3]));

    // R7: per-character flags only show when a character is present
    a_r7_flags_need_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_stat[4:2]) |-> line_stat[0]);

    // R10: fill level never exceeds the capacity of the selected mode
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= (fifo_mode ? CNW'(DEPTH) : CNW'(1)));
endmodule

bind uart_rx_lsr uart_rx_lsr_chk #(.DEPTH(DEPTH), .CNW($clog2(DEPTH + 1))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rd_stat_stb (rd_stat_stb),
    .fifo_mode   (fifo_mode),
    .fifo_count  (fifo_count),
    .line_stat   (line_stat),
    .rd_data     (rd_data)
);

// File: tb/tb_uart_rx_lsr.sv
module tb_uart_rx_lsr;
    localparam int BIT_CLKS = 32;

    typedef struct packed {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        logic       bi;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       rx_in = 1'b1;
    logic       fifo_mode = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       lsi_en = 1'b0;
    logic       rd_data_stb = 1'b0;
    logic       rd_stat_stb = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] line_stat;
    logic       lsi_irq;

    int   checks = 0;
    int   errors = 0;
    exp_t expq[$];

    uart_rx_lsr dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_in(rx_in),
        .fifo_mode(fifo_mode), .par_en(par_en), .par_even(par_even),
        .word_len(word_len), .lsi_en(lsi_en), .rd_data_stb(rd_data_stb),
        .rd_stat_stb(rd_stat_stb), .rd_data(rd_data), .line_stat(line_stat),
        .lsi_irq(lsi_irq)
    );

    always #2.5 clk = ~clk;

    // Enable every other clock: one bit is 16 enables = 32 clocks (R13).
    always @(posedge clk) sample_en <= rst_n ? ~sample_en : 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Driver: one frame with the current configuration; queues the expected item.
    task automatic send_char(input logic [7:0] d, input bit bad_par,
                             input bit stop_hi, input bit expect_it);
        int nb = 5 + int'(word_len);
        logic [7:0] m = d & 8'((1 << nb) - 1);
        logic pbit = (^m) ^ ~par_even ^ bad_par;
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) hold_bit(m[i]);
        if (par_en) hold_bit(pbit);
        hold_bit(stop_hi);
        if (stop_hi) begin
            hold_bit(1'b1);
            hold_bit(1'b1);
        end
        if (expect_it) expq.push_back('{m, par_en & bad_par, ~stop_hi, 1'b0});
    endtask

    task automatic pulse_data();
        rd_data_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_stat();
        rd_stat_stb = 1'b1;
        @(negedge clk);
        rd_stat_stb = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare the head with the oldest expected item, then remove it.
    task automatic check_head(input string req);
        exp_t e = expq.pop_front();
        chk({req, " R1 ready"}, int'(line_stat[0]), 1);
        chk({req, " data"}, int'(rd_data), int'(e.d));
        chk({req, " R7 pe"}, int'(line_stat[2]), int'(e.pe));
        chk({req, " R7 fe"}, int'(line_stat[3]), int'(e.fe));
        chk({req, " R7 bi"}, int'(line_stat[4]), int'(e.bi));
        pulse_data();
    endtask

    task automatic drain(input string req);
        while (expq.size() > 0) check_head(req);
        chk({req, " R1 empty after reads"}, int'(line_stat[0]), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 status", int'(line_stat), 0);
        chk("R12 data", int'(rd_data), 0);
        chk("R12 irq", int'(lsi_irq), 0);

        // R13 / R1: plain 8-bit frame, single-slot mode
        send_char(8'hA5, 0, 1, 1);
        drain("R13 8N1");

        // R2: short low glitch stores nothing
        rx_in = 1'b0;
        repeat (6) @(negedge clk);
        rx_in = 1'b1;
        repeat (20 * BIT_CLKS) @(negedge clk);
        chk("R2 glitch rejected", int'(line_stat[0]), 0);

        // R3: five bits, odd parity correct
        word_len = 2'd0; par_en = 1'b1; par_even = 1'b0;
        send_char(8'hF5, 0, 1, 1);
        drain("R3 5-bit");
        word_len = 2'd3;

        // R4 / R7 / R8 / R11: per-entry parity flag in queue mode
        fifo_mode = 1'b1; par_even = 1'b1;
        send_char(8'h31, 0, 1, 1);
        send_char(8'h32, 1, 1, 1);
        send_char(8'h33, 0, 1, 1);
        lsi_en = 1'b1;
        chk("R11 no irq on clean head", int'(lsi_irq), 0);
        check_head("R7 head A");
        chk("R4 parity at head", int'(line_stat[2]), 1);
        chk("R11 irq on parity", int'(lsi_irq), 1);
        pulse_stat();
        chk("R8 parity cleared", int'(line_stat[2]), 0);
        chk("R8 data kept", int'(rd_data), 8'h32);
        chk("R11 irq drops", int'(lsi_irq), 0);
        void'(expq.pop_front());
        pulse_data();
        drain("R7 head C");
        lsi_en = 1'b0;
        par_en = 1'b0;

        // R5: low stop sample acts as next start bit
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(((8'h3C >> i) & 1) != 0);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(((8'h81 >> i) & 1) != 0);
        hold_bit(1'b1);
        hold_bit(1'b1);
        expq.push_back('{8'h3C, 1'b0, 1'b1, 1'b0});
        expq.push_back('{8'h81, 1'b0, 1'b0, 1'b0});
        drain("R5 resync");

        // R6: long break gives one zero entry, then normal reception
        rx_in = 1'b0;
        repeat (30 * BIT_CLKS) @(negedge clk);
        hold_bit(1'b1);
        hold_bit(1'b1);
        expq.push_back('{8'h00, 1'b0, 1'b1, 1'b1});
        send_char(8'h5A, 0, 1, 1);
        drain("R6 break");

        // R9: single-slot overrun replaces the held character
        fifo_mode = 1'b0;
        lsi_en = 1'b1;
        send_char(8'h11, 0, 1, 0);
        send_char(8'h22, 0, 1, 0);
        chk("R9 overrun set", int'(line_stat[1]), 1);
        chk("R9 newest kept", int'(rd_data), 8'h22);
        chk("R11 irq on overrun", int'(lsi_irq), 1);
        pulse_stat();
        chk("R8 overrun cleared", int'(line_stat[1]), 0);
        pulse_data();
        chk("R9 one entry only", int'(line_stat[0]), 0);
        lsi_en = 1'b0;

        // R10: queue overrun drops the seventeenth character
        fifo_mode = 1'b1;
        for (int i = 0; i < 17; i++) send_char(8'(8'h40 + i), 0, 1, i < 16);
        chk("R10 overrun set", int'(line_stat[1]), 1);
        pulse_stat();
        chk("R10 overrun cleared", int'(line_stat[1]), 0);
        drain("R10 queue intact");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule